// File: doc/BRIEF.md
# Reset-Time Host Boot Packing DMA

This block loads a boot image straight after reset, with no software involved. Its channel settings come from reset defaults. These are:

- the destination index, 0x40000;
- a step of +1 per word;
- a count of 256 words;
- a control word of 0x161, whose bit 0 enables the host port.

While the load runs, the core is held idle with its program counter parked at 0x40004.

An external host streams 8-bit bytes over a valid/ready handshake. A byte moves only on a rising clock edge where `host_valid` and `host_ready` are both high. The host may hold `host_valid` high on every cycle; when `host_ready` is low it must keep its byte until it is taken. The block assembles six bytes into one 48-bit word, least-significant byte first. On the cycle the sixth byte is accepted, it drives a write of that word to the current internal address. The address then steps by one and the count drops by one.

When the count runs out, `host_ready` stays low for good and any further bytes are ignored. One cycle after the final write, a single-cycle `boot_done` pulse releases the core from idle at the fixed start vector.

Top module: `host_boot_dma`

## Requirements
- R1: In the first cycle after reset, `host_ready` is 1, `mem_we` is 0, `boot_done` is 0, `core_idle` is 1 and `core_pc` is 0x40004.
- R2: A byte offered while `host_valid` is low has no effect: it produces no write and does not shift the byte order of the word being packed.
- R3: Within a word, the first accepted byte lands in bits [7:0], the second in [15:8], and so on, with the sixth in bits [47:40].
- R4: `mem_we` is high in exactly the cycle in which the sixth byte of a word is accepted, and `mem_data` carries the complete word in that cycle.
- R5: The first word is written to address 0x40000, and each following word goes to the previous address plus one.
- R6: Exactly 256 words are written. From the cycle after the 256th write, `host_ready` is 0, and no further byte causes a write.
- R7: `boot_done` is high for exactly the one cycle after the final write. `core_idle` falls in that same cycle and stays low.
- R8: `core_pc` holds 0x40004 at all times after reset, before and after the release.
- R9: Bytes offered on every consecutive cycle are all accepted without loss, including across word boundaries.
- R10: Gaps in `host_valid` between the bytes of a word leave the bytes already packed intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; loads the boot defaults |
| host_data | input | 8 | Byte from the host |
| host_valid | input | 1 | Host offers `host_data` this cycle |
| host_ready | output | 1 | Block can take a byte this cycle |
| mem_addr | output | 20 | Internal write address |
| mem_data | output | 48 | Packed word to be written |
| mem_we | output | 1 | Write strobe for `mem_addr`/`mem_data` |
| boot_done | output | 1 | One-cycle pulse releasing the core |
| core_idle | output | 1 | Core held in idle while high |
| core_pc | output | 20 | Program counter value for the core (start vector) |

## Verification
The tightest collision is on the sixth byte of the last word. In that one edge, the word write, the clearing of the packing register and the count reaching zero all happen together. The next cycle then brings the release pulse and the closing of `host_ready`. The bench provokes this by keeping `host_valid` high straight through the final word and for several cycles after it. It then judges that the last word carries the right data and address, that `boot_done` rises exactly once one cycle later, and that the bytes still being offered produce no write. The other collision is a word write followed at once by the first byte of the next word; back-to-back streaming covers it, and the next word's data is checked for correct byte placement.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int BYTE_W        = 8;
  localparam int UNITS_PER_WORD = 6;
  localparam int WORD_W        = BYTE_W * UNITS_PER_WORD;
  localparam int ADDR_W        = 20;
  localparam logic [19:0] BOOT_BASE   = 20'h40000;
  localparam logic [19:0] BOOT_VECTOR = 20'h40004;
  localparam int BOOT_WORDS    = 256;
  localparam logic [31:0] BOOT_CTRL   = 32'h0000_0161;
  localparam int CTRL_EN_BIT   = 0;
endpackage

// File: rtl/boot_chan_regs.sv
module boot_chan_regs #(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter int STEP = 1,
  parameter int WORDS = 256,
  parameter logic [31:0] CTRL_INIT = 32'h1,
  parameter int EN_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_wr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              can_take,
  output logic              final_word
);
  localparam int CNT_W = $clog2(WORDS + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(WORDS);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [CNT_W-1:0] words_left;
  logic             port_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr   <= BASE;
      words_left <= CNT_INIT;
      port_en    <= CTRL_INIT[EN_BIT];
    end else if (word_wr && words_left != '0) begin
      cur_addr   <= cur_addr + STEP_V;
      words_left <= words_left - 1'b1;
    end
  end

  assign can_take   = port_en && (words_left != '0);
  assign final_word = (words_left == CNT_W'(1));
endmodule

// File: rtl/unit_packer.sv
module unit_packer #(
  parameter int UNIT_W = 8,
  parameter int UNITS  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic [UNIT_W-1:0]       unit_in,
  output logic                    word_out_vld,
  output logic [UNIT_W*UNITS-1:0] word_out
);
  localparam int IDX_W  = (UNITS > 1) ? $clog2(UNITS) : 1;
  localparam int HELD_W = UNIT_W * (UNITS - 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(UNITS - 1);

  logic [IDX_W-1:0]  slot;
  logic [HELD_W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
      held <= '0;
    end else if (take) begin
      if (slot == LAST) begin
        slot <= '0;
        held <= '0;
      end else begin
        held[slot*UNIT_W +: UNIT_W] <= unit_in;
        slot <= slot + 1'b1;
      end
    end
  end

  assign word_out_vld = take && (slot == LAST);
  assign word_out     = {unit_in, held};
endmodule

// File: rtl/core_release.sv
module core_release #(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] VECTOR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last_wr,
  output logic              done_pulse,
  output logic              idle,
  output logic [ADDR_W-1:0] pc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_pulse <= 1'b0;
      idle       <= 1'b1;
      pc         <= VECTOR;
    end else begin
      done_pulse <= last_wr && idle;
      if (last_wr) idle <= 1'b0;
    end
  end
endmodule

// File: rtl/host_boot_dma.sv
module host_boot_dma
  import boot_pkg::*;
#(
  parameter int UNIT_W = BYTE_W,
  parameter int UNITS  = UNITS_PER_WORD,
  parameter int AW     = ADDR_W,
  parameter logic [AW-1:0] BASE   = BOOT_BASE,
  parameter logic [AW-1:0] VECTOR = BOOT_VECTOR,
  parameter int WORDS  = BOOT_WORDS,
  parameter logic [31:0] CTRL_INIT = BOOT_CTRL
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [UNIT_W-1:0]       host_data,
  input  logic                    host_valid,
  output logic                    host_ready,
  output logic [AW-1:0]           mem_addr,
  output logic [UNIT_W*UNITS-1:0] mem_data,
  output logic                    mem_we,
  output logic                    boot_done,
  output logic                    core_idle,
  output logic [AW-1:0]           core_pc
);
  logic take, word_vld, final_word;

  assign take   = host_valid && host_ready;
  assign mem_we = word_vld;

  boot_chan_regs #(
    .ADDR_W(AW), .BASE(BASE), .STEP(1), .WORDS(WORDS),
    .CTRL_INIT(CTRL_INIT), .EN_BIT(CTRL_EN_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .word_wr(word_vld),
    .cur_addr(mem_addr), .can_take(host_ready), .final_word(final_word)
  );

  unit_packer #(.UNIT_W(UNIT_W), .UNITS(UNITS)) u_pack (
    .clk(clk), .rst_n(rst_n), .take(take), .unit_in(host_data),
    .word_out_vld(word_vld), .word_out(mem_data)
  );

  core_release #(.ADDR_W(AW), .VECTOR(VECTOR)) u_rel (
    .clk(clk), .rst_n(rst_n), .last_wr(word_vld && final_word),
    .done_pulse(boot_done), .idle(core_idle), .pc(core_pc)
  );
endmodule

// File: rtl/boot_dma_checker.sv
module boot_dma_checker #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_valid,
  input logic          host_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          boot_done,
  input logic          core_idle,
  input logic [AW-1:0] core_pc
);
  logic [AW-1:0] prev_addr;
  logic          wrote_once;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_addr  <= '0;
      wrote_once <= 1'b0;
    end else if (mem_we) begin
      prev_addr  <= mem_addr;
      wrote_once <= 1'b1;
    end
  end

  AST_WRITE_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (host_valid && host_ready)); // R4
  AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && wrote_once) |-> (mem_addr == prev_addr + 1'b1)); // R5
  AST_CLOSED_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !core_idle |-> (!host_ready && !mem_we)); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> !boot_done); // R7
  AST_DONE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> ($past(mem_we) && !core_idle)); // R7
  AST_IDLE_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !core_idle |=> !core_idle); // R7
  AST_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(core_pc)); // R8
endmodule

bind host_boot_dma boot_dma_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .boot_done(boot_done),
  .core_idle(core_idle), .core_pc(core_pc)
);

// File: tb/sim_host_boot_dma.sv
module sim_host_boot_dma;
  localparam int CLK_P = 10;
  localparam int WORDS = 256;
  localparam logic [19:0] BASE = 20'h40000;
  localparam logic [19:0] VEC  = 20'h40004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_data = '0;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic [19:0] mem_addr;
  logic [47:0] mem_data;
  logic        mem_we;
  logic        boot_done;
  logic        core_idle;
  logic [19:0] core_pc;

  int n_chk = 0;
  int n_bad = 0;
  int exp_words = 0;
  int exp_slot = 0;
  logic [39:0] exp_held = '0;
  logic pulse_due = 1'b0;
  int seed_b = 3;

  always #(CLK_P/2) clk = ~clk;

  host_boot_dma u0 (
    .clk(clk), .rst_n(rst_n), .host_data(host_data), .host_valid(host_valid),
    .host_ready(host_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_we(mem_we), .boot_done(boot_done), .core_idle(core_idle), .core_pc(core_pc)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one clock cycle: offer (or not) a byte, check outputs mid-cycle, update model
  task automatic cycle_byte(input logic [7:0] d, input logic v);
    bit rdy_exp, acc;
    @(negedge clk);
    host_valid = v;
    host_data  = d;
    #(CLK_P/4);
    rdy_exp = (exp_words < WORDS);
    acc = v && rdy_exp;
    chk(host_ready == rdy_exp, "R6 host_ready", 64'(host_ready), 64'(rdy_exp));
    if (acc && exp_slot == 5) begin
      chk(mem_we == 1'b1, "R4 write strobe", 64'(mem_we), 64'd1);
      chk(mem_data == {d, exp_held}, "R3 packed word", 64'(mem_data), 64'({d, exp_held}));
      chk(mem_addr == BASE + 20'(exp_words), "R5 address", 64'(mem_addr), 64'(BASE + 20'(exp_words)));
    end else begin
      chk(mem_we == 1'b0, "R2 no write", 64'(mem_we), 64'd0);
    end
    chk(boot_done == pulse_due, "R7 boot_done", 64'(boot_done), 64'(pulse_due));
    chk(core_idle == (exp_words < WORDS), "R7 core_idle", 64'(core_idle), 64'(exp_words < WORDS));
    chk(core_pc == VEC, "R8 core_pc", 64'(core_pc), 64'(VEC));
    @(posedge clk);
    pulse_due = 1'b0;
    if (acc) begin
      if (exp_slot == 5) begin
        exp_slot = 0;
        exp_held = '0;
        exp_words++;
        if (exp_words == WORDS) pulse_due = 1'b1;
      end else begin
        exp_held[exp_slot*8 +: 8] = d;
        exp_slot++;
      end
    end
  endtask

  function automatic logic [7:0] next_b();
    seed_b = (seed_b * 37 + 11) % 251;
    return 8'(seed_b);
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk(host_ready == 1'b1, "R1 ready", 64'(host_ready), 64'd1);
    chk(mem_we == 1'b0, "R1 we", 64'(mem_we), 64'd0);
    chk(boot_done == 1'b0, "R1 done", 64'(boot_done), 64'd0);
    chk(core_idle == 1'b1, "R1 idle", 64'(core_idle), 64'd1);
    chk(core_pc == VEC, "R1 pc", 64'(core_pc), 64'(VEC));
  endtask

  // R2 / R10: invalid cycles with junk data between bytes of a word
  task automatic t_gaps;
    for (int w = 0; w < 3; w++) begin
      for (int b = 0; b < 6; b++) begin
        cycle_byte(next_b(), 1'b1);
        cycle_byte(8'hA5, 1'b0);
        if (b == 2) cycle_byte(8'h5A, 1'b0);
      end
    end
  endtask

  // R3 / R9: exact placement with a distinct byte per slot, back to back
  task automatic t_burst;
    for (int w = 0; w < 8; w++)
      for (int b = 0; b < 6; b++)
        cycle_byte(8'((w << 4) | (b + 1)), 1'b1);
  endtask

  // R6 / R7 / R8: stream to the end, keep valid high afterwards
  task automatic t_finish;
    while (exp_words < WORDS) cycle_byte(next_b(), 1'b1);
    for (int k = 0; k < 10; k++) cycle_byte(next_b(), 1'b1);
    chk(exp_words == WORDS, "R6 word total", 64'(exp_words), 64'(WORDS));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_gaps();
    t_burst();
    t_finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule